// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block learns, per static load, the signed gap between the load's effective address and the value it brings back. Pointer-chasing code often shows a constant gap. Two cases produce one: nodes allocated at a fixed spacing, and a node stored next to the object it points at. Once the gap has repeated often enough, the block can supply a guessed value for that load during speculative runahead execution, when the real value is stuck behind an outer-cache miss. Dependent loads can then compute their addresses and prefetch instead of being dropped.

Training happens on a retire port fed by loads that complete in normal mode. Each one carries its program counter, its effective address and the loaded value. Loads whose gap is too large to belong to an address load are filtered out before they reach the table. A second port takes the program counter and address of a load that missed the outer cache during runahead. It answers one cycle later with a valid flag and a predicted value. No recovery is needed on a wrong guess, because runahead results are discarded anyway.

The table is a small set-associative store. Its set index comes from the low PC bits and its tag from the remaining PC bits. Each line holds a truncated delta and a saturating confidence counter. Replacement is least-recently-updated within the set.

Top module: `avd_predictor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pred_valid` is 0 and every line is empty, so no lookup predicts until the table has been trained.
- R2: The delta of a training load is `upd_addr - upd_data` in full 64-bit arithmetic. A prediction is `lkp_addr` minus the stored 16-bit delta sign-extended to 64 bits. `pred_value` is 0 whenever `pred_valid` is 0.
- R3: A training load whose 64-bit delta, read as signed, lies outside `[-MAX_DELTA, +MAX_DELTA]` neither allocates a line nor changes any line or replacement state.
- R4: A newly allocated line starts at confidence 0. A training hit with an equal delta raises confidence by one, saturating at 3. A hit with a different delta stores the new delta and sets confidence to 0.
- R5: A lookup predicts only when its PC matches a valid line in its set and that line's confidence is 2 or more.
- R6: A training load flagged with `upd_runahead = 1` leaves the table unchanged.
- R7: A lookup with `lkp_runahead = 0`, or without `lkp_valid`, produces no prediction.
- R8: The set index is `pc[1:0]` and the tag is `pc[31:2]`. On a training miss, the line written is the lowest-numbered empty way, else the way updated least recently; training hits also count as uses.
- R9: When training and a lookup touch the same line in one cycle, the lookup answers from the contents before that training.
- R10: `pred_valid` and `pred_value` appear on the clock edge after the lookup is presented and last one cycle.
- R11: Deltas of exactly `+MAX_DELTA` and `-MAX_DELTA` are admitted, and one step beyond either is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_valid | input | 1 | A load retires this cycle |
| upd_runahead | input | 1 | The retiring load completed in runahead mode |
| upd_pc | input | PC_W | Program counter of the retiring load |
| upd_addr | input | ADDR_W | Effective address of the retiring load |
| upd_data | input | ADDR_W | Value loaded by the retiring load |
| lkp_valid | input | 1 | A load missed the outer cache this cycle |
| lkp_runahead | input | 1 | The core is in runahead mode for that miss |
| lkp_pc | input | PC_W | Program counter of the missing load |
| lkp_addr | input | ADDR_W | Effective address of the missing load |
| pred_valid | output | 1 | A predicted value is offered |
| pred_value | output | ADDR_W | Predicted loaded value, 0 when none |

## Verification
A lookup presented before rising edge N yields its answer in the output register at edge N. A training load presented before edge N changes the table at edge N, so only lookups presented after that edge can see it. The bench drives both ports on the falling edge. At the following rising edge it computes the expected answer from its model state before any update, then applies the training to the model. It compares the outputs at the next falling edge, a full cycle after the stimulus. This keeps the same-cycle ordering of R9 and the one-cycle latency of R10 exact for every cycle, both in the directed cases and in the random traffic.

// File: rtl/avd_pkg.sv
package avd_pkg;

   // What a training load does to the line it selects.
   typedef enum logic [1:0] {
      ACT_IDLE    = 2'd0,
      ACT_CONFIRM = 2'd1,
      ACT_RETRAIN = 2'd2,
      ACT_ALLOC   = 2'd3
   } upd_act_e;

endpackage

// File: rtl/avd_delta_calc.sv
module avd_delta_calc #(
   parameter int ADDR_W    = 64,
   parameter int DELTA_W   = 16,
   parameter int MAX_DELTA = 4096
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ADDR_W-1:0]  data,
   output logic [DELTA_W-1:0] delta,
   output logic               in_range
);

   localparam logic signed [ADDR_W-1:0] HI_LIM = ADDR_W'(MAX_DELTA);
   localparam logic signed [ADDR_W-1:0] LO_LIM = -HI_LIM;

   logic signed [ADDR_W-1:0] diff;

   assign diff     = addr - data;
   assign in_range = (diff <= HI_LIM) && (diff >= LO_LIM);
   assign delta    = diff[DELTA_W-1:0];

endmodule

// File: rtl/avd_way_match.sv
module avd_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 30,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);

   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = vld[w] && (tags[w] == tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (eq[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |eq;

endmodule

// File: rtl/avd_lru_set.sv
module avd_lru_set #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [WAYS-1:0]  vld,
   output logic [WAY_W-1:0] victim
);

   // Age 0 is the most recent use, WAYS-1 the oldest; ages stay a permutation.
   logic [WAYS-1:0][WAY_W-1:0] age_q;
   logic                       free_found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
      end else if (touch) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)          age_q[w] <= '0;
            else if (age_q[w] < age_q[touch_way]) age_q[w] <= age_q[w] + 1'b1;
         end
      end
   end

   always_comb begin
      victim     = '0;
      free_found = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!free_found && !vld[w]) begin
            victim     = WAY_W'(w);
            free_found = 1'b1;
         end
      end
      if (!free_found) begin
         for (int w = 0; w < WAYS; w++) begin
            if (age_q[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
   import avd_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int ADDR_W      = 64,
   parameter int DELTA_W     = 16,
   parameter int MAX_DELTA   = 4096,
   parameter int SETS        = 4,
   parameter int WAYS        = 4,
   parameter int CONF_W      = 2,
   parameter int CONF_THRESH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic              upd_runahead,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [ADDR_W-1:0] upd_data,
   input  logic              lkp_valid,
   input  logic              lkp_runahead,
   input  logic [PC_W-1:0]   lkp_pc,
   input  logic [ADDR_W-1:0] lkp_addr,
   output logic              pred_valid,
   output logic [ADDR_W-1:0] pred_value
);

   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = PC_W - IDX_W;
   localparam int N     = SETS * WAYS;
   localparam int ENT_W = IDX_W + WAY_W;
   localparam logic [CONF_W-1:0] CONF_MAX = '1;
   localparam logic [CONF_W-1:0] CONF_THR = CONF_W'(CONF_THRESH);

   // Elaboration-time parameter checks
   if (MAX_DELTA < 0 || MAX_DELTA > 2 ** (DELTA_W - 1) - 1) begin : g_bad_max
      $error("MAX_DELTA must fit the signed stored delta");
   end
   if (SETS < 2 || (2 ** IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WAYS < 2 || (2 ** WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (DELTA_W >= ADDR_W || IDX_W >= PC_W) begin : g_bad_width
      $error("width parameters out of range");
   end
   if (CONF_THRESH < 1 || CONF_THRESH > 2 ** CONF_W - 1) begin : g_bad_thr
      $error("CONF_THRESH must be reachable by the counter");
   end

   // Table storage, entry index = {set, way}
   logic [N-1:0]              vld_q;
   logic [N-1:0][TAG_W-1:0]   tag_q;
   logic [N-1:0][DELTA_W-1:0] delta_q;
   logic [N-1:0][CONF_W-1:0]  conf_q;

   // ---------------- training side ----------------
   logic [IDX_W-1:0]           u_set;
   logic [TAG_W-1:0]           u_tag;
   logic [DELTA_W-1:0]         u_delta;
   logic                       upd_in_range;
   logic                       upd_en;
   logic [WAYS-1:0]            u_vld;
   logic [WAYS-1:0][TAG_W-1:0] u_tags;
   logic                       u_hit;
   logic [WAY_W-1:0]           u_hit_way;
   logic [WAY_W-1:0]           u_victim;
   logic [WAY_W-1:0]           u_way;
   logic [ENT_W-1:0]           wr_idx;
   logic [SETS-1:0][WAY_W-1:0] set_victim;
   upd_act_e                   act;
   logic [CONF_W-1:0]          new_conf;

   assign u_set = upd_pc[IDX_W-1:0];
   assign u_tag = upd_pc[PC_W-1:IDX_W];

   avd_delta_calc #(
      .ADDR_W    (ADDR_W),
      .DELTA_W   (DELTA_W),
      .MAX_DELTA (MAX_DELTA)
   ) u_upd_delta (
      .addr     (upd_addr),
      .data     (upd_data),
      .delta    (u_delta),
      .in_range (upd_in_range)
   );

   assign upd_en = upd_valid && !upd_runahead && upd_in_range;

   for (genvar w = 0; w < WAYS; w++) begin : g_upd_gather
      assign u_vld[w]  = vld_q[{u_set, WAY_W'(w)}];
      assign u_tags[w] = tag_q[{u_set, WAY_W'(w)}];
   end

   avd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd_match (
      .vld     (u_vld),
      .tags    (u_tags),
      .tag     (u_tag),
      .hit     (u_hit),
      .hit_way (u_hit_way)
   );

   assign u_victim = set_victim[u_set];
   assign u_way    = u_hit ? u_hit_way : u_victim;
   assign wr_idx   = {u_set, u_way};

   for (genvar s = 0; s < SETS; s++) begin : g_lru
      avd_lru_set #(.WAYS(WAYS)) u_lru (
         .clk       (clk),
         .rst_n     (rst_n),
         .touch     (upd_en && (u_set == IDX_W'(s))),
         .touch_way (u_way),
         .vld       (vld_q[s*WAYS +: WAYS]),
         .victim    (set_victim[s])
      );
   end

   always_comb begin
      act = ACT_IDLE;
      if (upd_en) begin
         if (!u_hit)                      act = ACT_ALLOC;
         else if (delta_q[wr_idx] == u_delta) act = ACT_CONFIRM;
         else                             act = ACT_RETRAIN;
      end
   end

   always_comb begin
      case (act)
         ACT_CONFIRM: new_conf = (conf_q[wr_idx] == CONF_MAX) ? CONF_MAX
                                                              : conf_q[wr_idx] + 1'b1;
         default:     new_conf = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= '0;
         tag_q   <= '0;
         delta_q <= '0;
         conf_q  <= '0;
      end else if (act != ACT_IDLE) begin
         vld_q[wr_idx]   <= 1'b1;
         tag_q[wr_idx]   <= u_tag;
         delta_q[wr_idx] <= u_delta;
         conf_q[wr_idx]  <= new_conf;
      end
   end

   // ---------------- lookup side ----------------
   logic [IDX_W-1:0]           l_set;
   logic [TAG_W-1:0]           l_tag;
   logic [WAYS-1:0]            l_vld;
   logic [WAYS-1:0][TAG_W-1:0] l_tags;
   logic                       l_hit;
   logic [WAY_W-1:0]           l_hit_way;
   logic [ENT_W-1:0]           l_idx;
   logic                       l_fire;
   logic [ADDR_W-1:0]          l_value;
   logic                       pred_valid_q;
   logic [ADDR_W-1:0]          pred_value_q;

   assign l_set = lkp_pc[IDX_W-1:0];
   assign l_tag = lkp_pc[PC_W-1:IDX_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_lkp_gather
      assign l_vld[w]  = vld_q[{l_set, WAY_W'(w)}];
      assign l_tags[w] = tag_q[{l_set, WAY_W'(w)}];
   end

   avd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lkp_match (
      .vld     (l_vld),
      .tags    (l_tags),
      .tag     (l_tag),
      .hit     (l_hit),
      .hit_way (l_hit_way)
   );

   assign l_idx   = {l_set, l_hit_way};
   assign l_fire  = lkp_valid && lkp_runahead && l_hit && (conf_q[l_idx] >= CONF_THR);
   assign l_value = lkp_addr - ADDR_W'($signed(delta_q[l_idx]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_valid_q <= 1'b0;
         pred_value_q <= '0;
      end else begin
         pred_valid_q <= l_fire;
         pred_value_q <= l_fire ? l_value : '0;
      end
   end

   assign pred_valid = pred_valid_q;
   assign pred_value = pred_value_q;

endmodule

// File: rtl/avd_predictor_chk.sv
module avd_predictor_chk #(
   parameter int N       = 16,
   parameter int TAG_W   = 30,
   parameter int DELTA_W = 16,
   parameter int CONF_W  = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      upd_valid,
   input logic                      upd_runahead,
   input logic                      lkp_valid,
   input logic                      lkp_runahead,
   input logic                      pred_valid,
   input logic                      upd_in_range,
   input logic [N-1:0]              vld_q,
   input logic [N-1:0][TAG_W-1:0]   tag_q,
   input logic [N-1:0][DELTA_W-1:0] delta_q,
   input logic [N-1:0][CONF_W-1:0]  conf_q
);

   // R1: reset leaves no prediction on the following edge
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !pred_valid);

   // R7: every prediction traces back to a runahead miss one cycle earlier
   p_pred_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> $past(lkp_valid && lkp_runahead));

   // R6: without a normal-mode training load the table holds still
   p_spec_train_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && !upd_runahead) |=>
         ($stable(vld_q) && $stable(tag_q) && $stable(delta_q) && $stable(conf_q)));

   // R3: a wide delta touches nothing
   p_wide_delta_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_runahead && !upd_in_range) |=>
         ($stable(vld_q) && $stable(tag_q) && $stable(delta_q) && $stable(conf_q)));

endmodule

bind avd_predictor avd_predictor_chk #(
   .N       (N),
   .TAG_W   (TAG_W),
   .DELTA_W (DELTA_W),
   .CONF_W  (CONF_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .upd_valid    (upd_valid),
   .upd_runahead (upd_runahead),
   .lkp_valid    (lkp_valid),
   .lkp_runahead (lkp_runahead),
   .pred_valid   (pred_valid),
   .upd_in_range (upd_in_range),
   .vld_q        (vld_q),
   .tag_q        (tag_q),
   .delta_q      (delta_q),
   .conf_q       (conf_q)
);

// File: tb/avd_predictor_tb.sv
module avd_predictor_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MAXD       = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0, upd_runahead = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [63:0] upd_addr = '0, upd_data = '0;
   logic        lkp_valid = 1'b0, lkp_runahead = 1'b0;
   logic [31:0] lkp_pc = '0;
   logic [63:0] lkp_addr = '0;
   logic        pred_valid;
   logic [63:0] pred_value;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   avd_predictor u_dut (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_runahead(upd_runahead), .upd_pc(upd_pc),
      .upd_addr(upd_addr), .upd_data(upd_data),
      .lkp_valid(lkp_valid), .lkp_runahead(lkp_runahead), .lkp_pc(lkp_pc),
      .lkp_addr(lkp_addr),
      .pred_valid(pred_valid), .pred_value(pred_value)
   );

   // ---------------- reference model ----------------
   bit          m_vld   [16];
   logic [29:0] m_tag   [16];
   logic [15:0] m_delta [16];
   int          m_conf  [16];
   int          m_age   [4][4];

   function automatic void m_reset();
      for (int e = 0; e < 16; e++) begin
         m_vld[e] = 0; m_tag[e] = '0; m_delta[e] = '0; m_conf[e] = 0;
      end
      for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) m_age[s][w] = w;
   endfunction

   function automatic void m_predict(input bit en, input logic [31:0] pc,
                                     input logic [63:0] addr,
                                     output bit pv, output logic [63:0] val);
      int s = int'(pc[1:0]);
      pv = 0; val = '0;
      if (!en) return;
      for (int w = 0; w < 4; w++) begin
         int e = s*4 + w;
         if (m_vld[e] && m_tag[e] == pc[31:2] && m_conf[e] >= 2) begin
            pv  = 1;
            val = addr - {{48{m_delta[e][15]}}, m_delta[e]};
         end
      end
   endfunction

   function automatic void m_update(input logic [31:0] pc, input logic [63:0] addr,
                                    input logic [63:0] data);
      logic signed [63:0] d = addr - data;
      int s = int'(pc[1:0]);
      int way = -1;
      int e, a_t;
      if (d > 64'sd4096 || d < -64'sd4096) return;
      for (int w = 0; w < 4; w++)
         if (m_vld[s*4+w] && m_tag[s*4+w] == pc[31:2]) way = w;
      if (way >= 0) begin
         e = s*4 + way;
         if (m_delta[e] == d[15:0]) m_conf[e] = (m_conf[e] < 3) ? m_conf[e] + 1 : 3;
         else begin m_delta[e] = d[15:0]; m_conf[e] = 0; end
      end else begin
         for (int w = 3; w >= 0; w--) if (!m_vld[s*4+w]) way = w;
         if (way < 0) for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) way = w;
         e = s*4 + way;
         m_vld[e] = 1; m_tag[e] = pc[31:2]; m_delta[e] = d[15:0]; m_conf[e] = 0;
      end
      a_t = m_age[s][way];
      for (int w = 0; w < 4; w++) begin
         if (w == way) m_age[s][w] = 0;
         else if (m_age[s][w] < a_t) m_age[s][w] = m_age[s][w] + 1;
      end
   endfunction

   // ---------------- check helpers ----------------
   task automatic check(input bit ok, input string req,
                        input logic [64:0] act, input logic [64:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual valid=%0b value=%h expected valid=%0b value=%h",
                  req, act[64], act[63:0], exp[64], exp[63:0]);
      end
   endtask

   // Drive at falling edge, model at rising edge, compare at next falling edge.
   task automatic cyc(input bit uv, input bit ur, input logic [31:0] upc,
                      input logic [63:0] ua, input logic [63:0] ud,
                      input bit lv, input bit lr, input logic [31:0] lpc,
                      input logic [63:0] la, input string req);
      bit          epv;
      logic [63:0] ev;
      upd_valid = uv; upd_runahead = ur; upd_pc = upc; upd_addr = ua; upd_data = ud;
      lkp_valid = lv; lkp_runahead = lr; lkp_pc = lpc; lkp_addr = la;
      @(posedge clk);
      m_predict(lv && lr, lpc, la, epv, ev);
      if (uv && !ur) m_update(upc, ua, ud);
      @(negedge clk);
      check({pred_valid, pred_value} === {epv, ev}, req,
            {pred_valid, pred_value}, {epv, ev});
   endtask

   task automatic train(input logic [31:0] pc, input logic [63:0] d, input string req);
      logic [63:0] a = {$urandom, $urandom};
      cyc(1, 0, pc, a, a - d, 0, 0, '0, '0, req);
   endtask

   task automatic look(input logic [31:0] pc, input string req);
      logic [63:0] a = {$urandom, $urandom};
      cyc(0, 0, '0, '0, '0, 1, 1, pc, a, req);
   endtask

   task automatic expect_pred(input bit want, input string req);
      checks++;
      if (pred_valid !== want) begin
         errors++;
         $display("FAIL %s: actual valid=%0b expected valid=%0b", req, pred_valid, want);
      end
   endtask

   localparam logic [31:0] PC_A = 32'h0000_1230;
   localparam logic [31:0] PC_B = 32'h0000_2230;
   localparam logic [31:0] PC_C = 32'h0000_3232;
   localparam logic [31:0] PC_D = 32'h0000_4233;

   initial begin
      void'($urandom(32'd1357));
      m_reset();
      repeat (3) @(negedge clk);
      checks++;
      if (pred_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: actual valid=%0b expected valid=0 during reset", pred_valid);
      end
      rst_n = 1'b1;
      look(PC_A, "R1 empty table after reset");

      // threshold and value
      train(PC_A, 64'd64, "R4 alloc");
      train(PC_A, 64'd64, "R4 confirm");
      look(PC_A, "R5 confidence 1 below threshold");
      expect_pred(0, "R5 no prediction at confidence 1");
      train(PC_A, 64'd64, "R4 confirm");
      look(PC_A, "R2 R5 predicted value addr-64");
      expect_pred(1, "R5 prediction at confidence 2");
      cyc(0, 0, '0, '0, '0, 0, 0, '0, '0, "R10 prediction lasts one cycle");
      expect_pred(0, "R10 single cycle pulse");
      cyc(0, 0, '0, '0, '0, 1, 0, PC_A, 64'h1000, "R7 lookup in normal mode");

      // runahead training dropped
      for (int i = 0; i < 4; i++) begin
         logic [63:0] a = {$urandom, $urandom};
         cyc(1, 1, PC_A, a, a - 64'd128, 0, 0, '0, '0, "R6 runahead training");
      end
      look(PC_A, "R6 delta still 64");

      // range filter and boundaries
      train(PC_A, 64'd4097, "R3 wide positive");
      look(PC_A, "R3 entry unchanged");
      train(PC_A, -64'sd4097, "R3 wide negative");
      look(PC_A, "R11 R3 entry unchanged");
      for (int i = 0; i < 3; i++) train(PC_B, 64'd4097, "R3 no allocation");
      look(PC_B, "R3 wide PC never allocated");
      expect_pred(0, "R3 wide PC not predicted");
      for (int i = 0; i < 3; i++) train(PC_B, 64'd4096, "R11 positive edge");
      look(PC_B, "R11 +MAX admitted");
      expect_pred(1, "R11 +MAX predicted");
      for (int i = 0; i < 3; i++) train(PC_C, -64'sd4096, "R11 negative edge");
      look(PC_C, "R11 -MAX admitted");

      // saturation and retraining
      for (int i = 0; i < 5; i++) train(PC_A, 64'd64, "R4 saturate");
      look(PC_A, "R4 counter saturated");
      expect_pred(1, "R4 saturated counter still predicts");
      train(PC_A, 64'd32, "R4 mismatch");
      look(PC_A, "R4 confidence reset");
      expect_pred(0, "R4 no prediction after mismatch");
      train(PC_A, 64'd32, "R4 confirm new");
      train(PC_A, 64'd32, "R4 confirm new");
      look(PC_A, "R4 new delta predicted");

      // LRU in set 1
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < 3; i++) train(32'h0001_0001 + 32'(k) * 32'h100, 64'd16, "R8 fill");
      train(32'h0001_0001, 64'd16, "R8 touch way of first PC");
      for (int i = 0; i < 3; i++) train(32'h0001_0401, 64'd24, "R8 fifth PC");
      look(32'h0001_0101, "R8 least recent evicted");
      expect_pred(0, "R8 evicted PC");
      look(32'h0001_0001, "R8 touched PC kept");
      expect_pred(1, "R8 kept PC");
      look(32'h0001_0401, "R8 newcomer predicts");

      // same-cycle update and lookup
      train(PC_D, 64'd8, "R9 prep");
      train(PC_D, 64'd8, "R9 prep");
      begin
         logic [63:0] a = {$urandom, $urandom};
         cyc(1, 0, PC_D, a, a - 64'd8, 1, 1, PC_D, a, "R9 lookup sees old confidence");
      end
      expect_pred(0, "R9 old contents");
      look(PC_D, "R9 update visible next cycle");

      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         int          pi = int'($urandom_range(0, 9));
         int          li = int'($urandom_range(0, 9));
         logic [31:0] upc = 32'h0040_0000 | (32'(pi) << 4) | 32'(pi % 4);
         logic [31:0] lpc = 32'h0040_0000 | (32'(li) << 4) | 32'(li % 4);
         logic [63:0] ua = {$urandom, $urandom};
         logic [63:0] la = {$urandom, $urandom};
         int          sel = int'($urandom_range(0, 99));
         logic [63:0] d;
         if (sel < 70)      d = 64'(pi * 24 - 100);
         else if (sel < 85) d = 64'($signed($urandom_range(0, 2*MAXD+2)) - MAXD - 1);
         else               d = {$urandom, $urandom};
         cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, upc, ua, ua - d,
             $urandom_range(0, 1) == 1, $urandom_range(0, 5) != 0, lpc, la,
             "R2 R4 R5 R8 random traffic");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule